// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

This block is a small up-counter, four bits wide by default. Every change of its state happens on the rising clock edge. A synchronous active-low clear takes first priority. An active-low load comes next and copies a parallel word into the counter. Last comes counting, which advances the value by one only when two separate enables are both high.

The two enables have different jobs. The run enable only gates the increment. The chain enable gates the increment and also the combinational carry output. That carry output goes high when the count is at its maximum while the chain enable is high.

To build a wider counter, connect the carry output of each stage to the chain enable of the next stage. All stages share one clock, one clear, one load and one run enable. The whole chain then acts as one synchronous counter, and the look-ahead carry needs no extra stage of registers.

Top module: `casc_bin_counter`

## Requirements
- R1: When rst_n is 0 at a rising edge, count becomes all zeros whatever load_n, en_run, en_chain and load_val are, and carry_out is then 0.
- R2: When rst_n is 1 and load_n is 0 at a rising edge, count takes the value of load_val whatever the two enables are.
- R3: When rst_n and load_n are both 1 and en_run and en_chain are both 1 at a rising edge, count increases by one as an unsigned number whose bit 0 is the least significant.
- R4: When rst_n and load_n are both 1 and either en_run or en_chain is 0 at a rising edge, count keeps its value.
- R5: carry_out is combinational. It is 1 exactly when en_chain is 1 and count is all ones (15 at the default width).
- R6: en_run has no effect on carry_out. At count 15 with en_chain at 1, carry_out stays 1 whether en_run is 0 or 1.
- R7: Counting up from all ones wraps to all zeros, and no carry state is kept inside the block.
- R8: Three stages chained as described (the carry_out of each stage drives the en_chain of the next; clock, clear, load and run are shared) count as one 12-bit counter from 0 to 4095, then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_run | input | 1 | Run enable; gates counting only |
| en_chain | input | 1 | Chain enable; gates counting and carry_out |
| load_val | input | WIDTH | Parallel data loaded when load_n is 0 |
| count | output | WIDTH | Present counter value, bit 0 least significant |
| carry_out | output | 1 | High when en_chain is 1 and count is all ones |

## Verification
Several functions can be requested in the same cycle, so priority needs checking. The bench asserts clear at the same edge as load and both enables, and expects zero. It asserts load at the same edge as both enables, and expects the loaded word rather than the incremented one. A second case is that carry decoding and hold fall in the same cycle. The bench holds the count at 15 and toggles each enable in turn. carry_out must follow en_chain and must not follow en_run. Each expected value comes from a reference model in the bench and passes through a scoreboard queue. The value is compared one edge later, while the inputs that produced it are still applied.

// File: rtl/cnt_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes: used by every module of the counter hierarchy.
package cnt_pkg;

    // Operation chosen for the coming clock edge (clear is handled by the register).
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_select.sv
// Module: picks the next operation of the counter from the control inputs.
// Assumes: clear is applied separately by the state register and has
// priority above everything decoded here; load beats counting.
module cnt_op_select
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_run,
    input  logic    en_chain,
    output cnt_op_e op
);

    // Priority decode: load, then count (both enables), otherwise hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (en_run && en_chain)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next_value.sv
// Module: computes the value the counter takes at the next rising edge.
// Assumes: unsigned binary with bit 0 least significant; wraps modulo 2**WIDTH.
module cnt_next_value
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Select load data, the incremented value or the held value.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = load_val;
            OP_COUNT: nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_term_detect.sv
// Module: look-ahead carry for cascading; high at the all-ones count while
// the chain enable is high.
// Assumes: purely combinational; the run enable is deliberately not an input.
module cnt_term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_chain,
    output logic             term
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // Compare against the terminal value and gate with the chain enable.
    always_comb begin
        term = en_chain && (cur == ALL_ONES);
    end

endmodule

// File: rtl/casc_bin_counter.sv
// Module: cascadable synchronous loadable up-counter (top level).
// Assumes: single clock; every control acts at the rising edge only;
// priority clear > load > count > hold.
module casc_bin_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_run,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    cnt_op_e          op;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_nxt;

    cnt_op_select u_op_select (
        .load_n   (load_n),
        .en_run   (en_run),
        .en_chain (en_chain),
        .op       (op)
    );

    cnt_next_value #(.WIDTH(WIDTH)) u_next_value (
        .op       (op),
        .cur      (cnt_q),
        .load_val (load_val),
        .nxt      (cnt_nxt)
    );

    cnt_term_detect #(.WIDTH(WIDTH)) u_term_detect (
        .cur      (cnt_q),
        .en_chain (en_chain),
        .term     (carry_out)
    );

    // State register: synchronous clear wins over every other operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    assign count = cnt_q;

endmodule

// File: rtl/casc_bin_counter_chk.sv
// Checker: temporal properties of the cascadable counter, bound to the top.
// Assumes: observes ports only.
module casc_bin_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             en_run,
    input logic             en_chain,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic armed = 1'b0;

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) armed <= 1'b1;

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!armed)
        !rst_n |=> (count == '0) && !carry_out); // R1

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(load_val)); // R2

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_run && en_chain) |=> count == WIDTH'($past(count) + 1'b1)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_run && en_chain)) |=> $stable(count)); // R4

    AST_CARRY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == (en_chain && count == ALL_ONES)); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_run && en_chain && count == ALL_ONES) |=> count == '0); // R7

endmodule

bind casc_bin_counter casc_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .en_run    (en_run),
    .en_chain  (en_chain),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_casc_bin_counter.sv
module test_casc_bin_counter;

    localparam int W = 4;
    localparam int STAGES = 3;
    localparam int CW = W * STAGES;

    typedef struct {
        logic [W-1:0] cnt;
        logic         tc;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         en_run = 1'b0;
    logic         en_chain = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         carry_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t sb_q[$];
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;   // 125 MHz

    casc_bin_counter #(.WIDTH(W)) i_casc_bin_counter (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_run(en_run),
        .en_chain(en_chain), .load_val(load_val), .count(count),
        .carry_out(carry_out)
    );

    // Three-stage chain (R8)
    logic          c_rst_n = 1'b0;
    logic          c_load_n = 1'b1;
    logic          c_run = 1'b0;
    logic [W-1:0]  c_cnt [STAGES];
    logic          c_tc [STAGES];
    logic          c_en [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign c_en[g] = 1'b1;
        end else begin : g_rest
            assign c_en[g] = c_tc[g-1];
        end
        casc_bin_counter #(.WIDTH(W)) i_stage (
            .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .en_run(c_run),
            .en_chain(c_en[g]), .load_val('0), .count(c_cnt[g]),
            .carry_out(c_tc[g])
        );
    end

    function automatic logic [CW-1:0] chain_val();
        logic [CW-1:0] v;
        for (int k = 0; k < STAGES; k++) v[k*W +: W] = c_cnt[k];
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: apply one input vector at a falling edge and queue the expected result.
    task automatic apply(input logic r, input logic ld, input logic er,
                         input logic ec, input logic [W-1:0] d, input string req);
        exp_t e;
        @(negedge clk);
        rst_n = r; load_n = ld; en_run = er; en_chain = ec; load_val = d;
        if (!r)            model = '0;
        else if (!ld)      model = d;
        else if (er && ec) model = model + 1'b1;
        e.cnt = model;
        e.tc  = ec && (model == {W{1'b1}});
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: after each rising edge, pop and compare while inputs are still held.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (count !== e.cnt || carry_out !== e.tc) begin
                    fails++;
                    $display("FAIL %s: count=%0d carry=%b expected count=%0d carry=%b",
                             e.req, count, carry_out, e.cnt, e.tc);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, with load and both enables requested at the same time
        apply(0, 0, 1, 1, 4'd9,  "R1 reset state");
        apply(0, 0, 1, 1, 4'd9,  "R1 reset over load and count");
        // R2: load with enables off, and load over counting
        apply(1, 0, 0, 0, 4'd5,  "R2 load enables low");
        apply(1, 0, 1, 1, 4'd10, "R2 load over count");
        // R3: counting
        apply(1, 1, 1, 1, 4'd0,  "R3 count 10 to 11");
        apply(1, 1, 1, 1, 4'd3,  "R3 count 11 to 12");
        // R4: hold for each enable pattern
        apply(1, 1, 0, 1, 4'd7,  "R4 hold run low");
        apply(1, 1, 1, 0, 4'd7,  "R4 hold chain low");
        apply(1, 1, 0, 0, 4'd7,  "R4 hold both low");
        // R5/R6: terminal value
        apply(1, 0, 0, 0, 4'd13, "R2 load 13");
        apply(1, 1, 1, 1, 4'd0,  "R3 count to 14");
        apply(1, 1, 1, 1, 4'd0,  "R5 count to 15 carry high");
        apply(1, 1, 0, 1, 4'd0,  "R6 run low carry stays high");
        apply(1, 1, 1, 0, 4'd0,  "R5 chain low carry low");
        apply(1, 1, 0, 0, 4'd0,  "R5 both low carry low");
        apply(1, 1, 0, 1, 4'd0,  "R6 run low chain high carry high");
        // R7: wrap
        apply(1, 1, 1, 1, 4'd0,  "R7 wrap to zero");
        apply(1, 1, 1, 1, 4'd0,  "R7 count after wrap");
        // R1: reset together with load of all ones
        apply(1, 0, 0, 0, 4'd15, "R2 load 15");
        apply(0, 0, 1, 1, 4'd15, "R1 reset beats load at 15");
        apply(1, 0, 0, 0, 4'd15, "R2 load 15 chain low");
        apply(1, 1, 0, 1, 4'd0,  "R6 carry with run low");
        @(negedge clk);
        @(negedge clk);

        // R8: three-stage chain, full cycle and wrap
        c_rst_n = 1'b0;
        @(negedge clk);
        c_rst_n = 1'b1; c_run = 1'b1;
        for (int n = 1; n <= (1 << CW); n++) begin
            @(posedge clk);
            #2;
            checks++;
            if (chain_val() !== CW'(n)) begin
                fails++;
                $display("FAIL R8: chain=%0d expected %0d", chain_val(), CW'(n));
            end
        end
        finish_run();
    end

endmodule